// File: doc/BRIEF.md
# ADC Result Queue with Interrupt and Wake-Up

This block sits between a converter's sequencer and the processor's bus. Each time the sequencer finishes a conversion it presents a 12-bit result with a one-cycle push strobe. The result enters a small first-in first-out queue that holds up to four entries. Software reads a 16-bit result word. That word carries the oldest queued sample together with status bits. Each read strobe removes that sample from the queue.

A result that arrives while the queue is full is thrown away, and a sticky overflow bit is raised in the result word. Reading clears that bit. The interrupt line is high while the queue holds data, except for the single cycle after any read, when it drops low. The wake-up line obeys the same rule. When the touch configuration input carries the pen-detect code, the pen-down input appears in the result word and is also ORed into the wake-up line. Everything runs on one system clock. While that clock is stopped, nothing moves toward the output.

Top module: `adc_result_queue`

## Requirements
- R1: The queue holds up to four results and returns them in arrival order in bits 11:0 of the result word.
- R2: Bit 15 of the result word is 1 exactly when the queue holds at least one result, and a read strobe on a non-empty queue removes the oldest entry.
- R3: A push while the queue holds four results and no read strobe is present discards the new result and sets bit 14 of the result word.
- R4: Bit 14 stays set until the next read strobe and is 0 in the cycle after any read strobe.
- R5: A read strobe on an empty queue leaves the queue empty, and the result word then shows 0 in bits 11:0 and 0 in bit 15.
- R6: A push and a read strobe in the same cycle on a full queue both take effect, the queue stays at four entries, and bit 14 is not set.
- R7: The interrupt output equals "queue non-empty" in every cycle, except that it is 0 in the cycle right after a read strobe.
- R8: When touch_cfg equals 3'b101, bit 13 of the result word shows pen_down and the wake output is the interrupt condition ORed with pen_down. For any other touch_cfg value, bit 13 is 0 and the wake output equals the interrupt output.
- R9: After reset the queue is empty, bit 14 is clear, and both the interrupt and wake outputs are low. Bit 12 of the result word is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| res_push | input | 1 | One-cycle strobe from the sequencer: a result is ready |
| res_data | input | 12 | Conversion result that goes with res_push |
| rd_strobe | input | 1 | Software read of the result word; removes one entry |
| touch_cfg | input | 3 | Touch configuration field; 3'b101 enables pen-detect |
| pen_down | input | 1 | Pen-down detector level |
| rd_word | output | 16 | Result word: data 11:0, pen 13, overflow 14, done 15 |
| irq | output | 1 | Interrupt request |
| wake | output | 1 | Wake-up request |

## Verification
Two situations are the hardest to reach: a full queue meeting a push and a read in the same cycle, and a full queue meeting a lone push. Random traffic rarely keeps four results queued long enough for either to happen. The stimulus therefore mixes push-heavy random bursts with directed sequences. Those sequences fill the queue, then apply a fifth push with no read, and then apply a push and a read together. The one-cycle interrupt gap is exercised with back-to-back reads and with reads of an empty queue.

// File: rtl/adc_result_queue.sv
`timescale 1ns/1ps
module adc_result_queue #(
  parameter int DW = 12,
  parameter int DEPTH = 4,
  parameter logic [2:0] PEN_CODE = 3'b101
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          res_push,
  input  logic [DW-1:0] res_data,
  input  logic          rd_strobe,
  input  logic [2:0]    touch_cfg,
  input  logic          pen_down,
  output logic [DW+3:0] rd_word,
  output logic          irq,
  output logic          wake
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] FULL_CNT = DEPTH[AW:0];

  logic [DW-1:0] mem [DEPTH];
  logic [AW:0]   wptr, rptr;
  logic          ovf, rd_gap;

  wire [AW:0] count   = wptr - rptr;
  wire        empty   = (count == '0);
  wire        full    = (count == FULL_CNT);
  wire        pop     = rd_strobe && !empty;
  wire        accept  = res_push && (!full || pop);
  wire        drop    = res_push && full && !rd_strobe;
  wire        pen_on  = (touch_cfg == PEN_CODE);
  wire        pen_bit = pen_on && pen_down;

  always_ff @(posedge clk) begin
    if (accept) mem[wptr[AW-1:0]] <= res_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr   <= '0;
      rptr   <= '0;
      ovf    <= 1'b0;
      rd_gap <= 1'b0;
    end else begin
      if (accept) wptr <= wptr + 1'b1;
      if (pop)    rptr <= rptr + 1'b1;
      if (drop)           ovf <= 1'b1;
      else if (rd_strobe) ovf <= 1'b0;
      rd_gap <= rd_strobe;
    end
  end

  assign rd_word = {!empty, ovf, pen_bit, 1'b0,
                    empty ? {DW{1'b0}} : mem[rptr[AW-1:0]]};
  assign irq  = !empty && !rd_gap;
  assign wake = irq || pen_bit;

  p_count_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULL_CNT);
  p_pop_advances_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !res_push) |=> (count == $past(count) - 1'b1));
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (res_push && full && !rd_strobe) |=> (ovf && full));
  p_ovf_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_strobe |=> !ovf);
  p_empty_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && empty && !res_push) |=> empty);
  p_full_swap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (res_push && rd_strobe && full) |=> (full && !ovf));
  p_irq_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_strobe |=> !irq);
  p_wake_covers_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> wake);
endmodule

// File: tb/adc_result_queue_tb.sv
`timescale 1ns/1ps
module adc_result_queue_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        res_push = 1'b0;
  logic [11:0] res_data = '0;
  logic        rd_strobe = 1'b0;
  logic [2:0]  touch_cfg = '0;
  logic        pen_down = 1'b0;
  logic [15:0] rd_word;
  logic        irq, wake;

  int checks = 0;
  int fails = 0;
  bit done_flag = 0;

  logic [11:0] mq[$];
  bit m_ovf = 0;
  bit m_gap = 0;

  always #2 clk = ~clk;

  adc_result_queue dut_i (
    .clk(clk), .rst_n(rst_n), .res_push(res_push), .res_data(res_data),
    .rd_strobe(rd_strobe), .touch_cfg(touch_cfg), .pen_down(pen_down),
    .rd_word(rd_word), .irq(irq), .wake(wake));

  function automatic logic [15:0] exp_word(logic [2:0] cfg, logic pen);
    logic [11:0] d = (mq.size() > 0) ? mq[0] : 12'h000;
    return {mq.size() > 0, m_ovf, (cfg == 3'b101) && pen, 1'b0, d};
  endfunction

  function automatic logic exp_irq();
    return (mq.size() > 0) && !m_gap;
  endfunction

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_outputs();
    logic [15:0] ew = exp_word(touch_cfg, pen_down);
    logic ei = exp_irq();
    chk("R1 data", {4'h0, rd_word[11:0]}, {4'h0, ew[11:0]});
    chk("R2 done", {15'h0, rd_word[15]}, {15'h0, ew[15]});
    chk("R3 R4 overflow", {15'h0, rd_word[14]}, {15'h0, ew[14]});
    chk("R8 pen", {15'h0, rd_word[13]}, {15'h0, ew[13]});
    chk("R9 bit12", {15'h0, rd_word[12]}, 16'h0);
    chk("R7 irq", {15'h0, irq}, {15'h0, ei});
    chk("R8 wake", {15'h0, wake}, {15'h0, ei || ((touch_cfg == 3'b101) && pen_down)});
  endtask

  task automatic model_step();
    int sz = mq.size();
    bit pop = rd_strobe && sz > 0;
    bit set = res_push && sz == 4 && !rd_strobe;
    if (pop) void'(mq.pop_front());
    if (res_push && (sz < 4 || pop)) mq.push_back(res_data);
    if (set) m_ovf = 1;
    else if (rd_strobe) m_ovf = 0;
    m_gap = rd_strobe;
  endtask

  task automatic cycle(bit p, logic [11:0] d, bit r, logic [2:0] cfg, bit pen);
    @(negedge clk);
    res_push = p; res_data = d; rd_strobe = r; touch_cfg = cfg; pen_down = pen;
    #1;
    check_outputs();
    model_step();
    @(posedge clk);
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0a1c));
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    // R9 reset state
    chk("R9 reset irq", {15'h0, irq}, 16'h0);
    chk("R9 reset wake", {15'h0, wake}, 16'h0);
    chk("R9 reset word", rd_word, 16'h0);
    @(posedge clk);
    rst_n = 1'b1;

    // R5 empty reads
    cycle(0, 12'h000, 1, 3'b000, 0);
    cycle(0, 12'h000, 1, 3'b000, 0);
    cycle(0, 12'h000, 0, 3'b000, 0);
    // R1 fill, R3 overflow on fifth push
    for (int i = 0; i < 5; i++) cycle(1, 12'h100 + 12'(i), 0, 3'b000, 0);
    cycle(0, 12'h000, 0, 3'b000, 0);
    // R6 push and pop on full
    cycle(1, 12'hABC, 1, 3'b000, 0);
    cycle(0, 12'h000, 0, 3'b000, 0);
    // R8 pen with the code and without
    cycle(0, 12'h000, 0, 3'b101, 1);
    cycle(0, 12'h000, 0, 3'b100, 1);
    // R2 R4 R7 back-to-back reads draining
    for (int i = 0; i < 6; i++) cycle(0, 12'h000, 1, 3'b101, 1);
    cycle(0, 12'h000, 0, 3'b101, 0);
    cycle(0, 12'h000, 0, 3'b101, 1);

    for (int n = 0; n < 4000; n++) begin
      int phase = (n / 200) % 3;
      int pp = (phase == 0) ? 80 : (phase == 1) ? 40 : 20;
      int rp = (phase == 0) ? 20 : (phase == 1) ? 40 : 70;
      bit p = ($urandom % 100) < pp;
      bit r = ($urandom % 100) < rp;
      logic [2:0] cfg = (($urandom % 2) == 0) ? 3'b101 : 3'($urandom);
      cycle(p, 12'($urandom), r, cfg, 1'($urandom));
    end
    cycle(0, 12'h000, 0, 3'b000, 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule